// File: doc/BRIEF.md
# Dual-Output Edge Interrupt Bank

This block collects a parameterized number of interrupt sources (twelve by default) and turns them into two independent active-low request outputs, so that two separate hosts can each service the same set of events. Every source goes through a two-flop synchronizer. A shared edge-selection register then picks, for each source, rising edges, falling edges, both, or neither. A detected edge sets the source's status bit in the status copies of both output lines at once. Each line has its own mask, so each host can enable a different subset of the sources.

Software reaches the block through a byte-wide register port: address, write data, write strobe, read strobe and combinational read data. A control bit selects how status bits are acknowledged. In one mode, a read of a status byte clears the bits it returned. In the other mode, software writes ones to the bits it wants to clear. If a second edge arrives on a source whose status bit is still set, that edge is held in a one-deep buffer and sets the bit again once the first event has been acknowledged.

A small primary aggregator is included. It places this bank's two line requests at a chosen slot of two 8-bit summary vectors and fills the other slots from the request inputs of neighbouring banks. A host can therefore find out which bank needs service with a single look.

Top module: `irqb_bank`

## Requirements
- R1: After reset, every status bit is 0, every mask bit is 1, all edge selections are 0, the control register is 0, and both `irq0_n` and `irq1_n` are high.
- R2: Source i is configured by two bits in edge byte i/4 (address 0x10 + i/4), at bit offset (i mod 4)*2. The upper bit of the pair enables rising edges and the lower bit enables falling edges. A source whose two bits are both 0 never sets status.
- R3: A detected edge sets the source's bit in the status of line 0 and in the status of line 1. The two copies are cleared independently of each other.
- R4: For each line k, `irqk_n` is low exactly when some bit of (status_k & ~mask_k) is 1.
- R5: A mask bit of 1 keeps the corresponding set status bit from driving that line's output. Writing 0xFF to every mask byte of a line releases that line's output.
- R6: With control bit 0 (0x00) at 1, reading a status byte clears exactly the bits that the read returned, and writes to status bytes have no effect.
- R7: With control bit 0 at 0, writing 1 to a status bit clears it, writing 0 leaves it unchanged, and reads do not clear anything.
- R8: An edge that arrives while the source's status bit is already set is buffered. After the first clear the bit reads 1 again, and only a second clear leaves it at 0.
- R9: If an edge and a clear hit the same status bit in the same cycle, the bit remains 1.
- R10: The status and mask registers are ceil(N/8) bytes long and the edge register is ceil(2N/8) bytes long, all little-endian, with source 0 in bit 0 of the lowest byte. Line 0 status starts at 0x20 and its mask at 0x28; line 1 status starts at 0x30 and its mask at 0x38. Bit positions at or above N read 0. Reads of unmapped addresses return 0, and writes to unmapped addresses are ignored.
- R11: Bit n of `summary0` or `summary1` is 0 when bit n of SLOT_USED is 0. Otherwise it is this bank's line request when n equals SLOT, and the matching `peer_req` bit in every other slot.
- R12: When a source changes just after a clock edge, its status bit is still 0 after the next two rising edges and is 1 after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src | input | N | Raw interrupt sources, asynchronous to clk |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe (needed for clear-on-read) |
| rd_data | output | 8 | Read data for `addr`, combinational |
| irq0_n | output | 1 | Line 0 request, active low |
| irq1_n | output | 1 | Line 1 request, active low |
| peer_req0 | input | 8 | Line 0 requests of other banks, by slot |
| peer_req1 | input | 8 | Line 1 requests of other banks, by slot |
| summary0 | output | 8 | Line 0 bank summary |
| summary1 | output | 8 | Line 1 bank summary |

## Verification
The hardest case to reach from the ports is a clear and a fresh edge landing on the same status bit in the same cycle. An edge only reaches status three rising edges after the pin moves. The bench therefore changes the source just after a falling edge, counts exactly two rising edges, and then presents the write-one-to-clear so that it lands on the third. It then clears the bit once more, which shows that no stale buffered event was left behind. The buffered second event is handled in a similar way: the bench makes a second edge while the bit is still set and checks that three consecutive clear-on-read reads return the bit, the bit, and then zero.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
    // register map: control byte, then regions selected by upper address bits
    localparam logic [7:0] ADDR_CTRL = 8'h00;
    localparam logic [3:0] HI_EDGE   = 4'h1;   // 0x10..0x1F
    localparam logic [4:0] HI_ST0    = 5'h04;  // 0x20..0x27
    localparam logic [4:0] HI_MK0    = 5'h05;  // 0x28..0x2F
    localparam logic [4:0] HI_ST1    = 5'h06;  // 0x30..0x37
    localparam logic [4:0] HI_MK1    = 5'h07;  // 0x38..0x3F
    localparam int         LINES     = 2;
    localparam int         SUM_W     = 8;
endpackage

// File: rtl/irqb_edge.sv
module irqb_edge #(
    parameter int N = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   src_i,
    input  logic [2*N-1:0] cfg_i,
    output logic [N-1:0]   hit_o
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] prev;
    } edge_state_t;

    edge_state_t st_d, st_q;
    logic [N-1:0] rise_en, fall_en;

    for (genvar i = 0; i < N; i++) begin : g_cfg
        assign rise_en[i] = cfg_i[2*i+1];
        assign fall_en[i] = cfg_i[2*i];
    end

    always_comb begin
        st_d      = st_q;
        st_d.s1   = src_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
        hit_o     = (st_q.s2 & ~st_q.prev & rise_en) |
                    (~st_q.s2 & st_q.prev & fall_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irqb_line.sv
module irqb_line #(
    parameter int N  = 12,
    parameter int SB = (N + 7) / 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hit_i,
    input  logic         cor_i,
    input  logic         sel_stat_i,
    input  logic         sel_mask_i,
    input  logic [2:0]   byte_i,
    input  logic         rd_en_i,
    input  logic         wr_en_i,
    input  logic [7:0]   wr_data_i,
    output logic [N-1:0] status_o,
    output logic [N-1:0] mask_o,
    output logic         req_o
);
    typedef struct packed {
        logic [N-1:0] status;
        logic [N-1:0] pend;
        logic [N-1:0] mask;
    } line_state_t;

    line_state_t ln_d, ln_q;
    logic [SB*8-1:0] clr_pad, mask_pad;
    logic [N-1:0]    clr;

    always_comb begin
        clr_pad = '0;
        if (sel_stat_i) begin
            if (cor_i && rd_en_i)
                clr_pad[int'(byte_i)*8 +: 8] = 8'hFF;
            else if (!cor_i && wr_en_i)
                clr_pad[int'(byte_i)*8 +: 8] = wr_data_i;
        end
        clr = clr_pad[N-1:0] & ln_q.status;

        ln_d        = ln_q;
        // a clear pulls in a buffered event; a fresh edge always wins
        ln_d.status = (ln_q.status & ~clr) | hit_i | (clr & ln_q.pend);
        ln_d.pend   = (~clr & (ln_q.pend | (hit_i & ln_q.status))) |
                      (clr & hit_i & ln_q.pend);

        mask_pad          = '0;
        mask_pad[N-1:0]   = ln_q.mask;
        if (sel_mask_i && wr_en_i)
            mask_pad[int'(byte_i)*8 +: 8] = wr_data_i;
        ln_d.mask = mask_pad[N-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ln_q.status <= '0;
            ln_q.pend   <= '0;
            ln_q.mask   <= '1;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign status_o = ln_q.status;
    assign mask_o   = ln_q.mask;
    assign req_o    = |(ln_q.status & ~ln_q.mask);

    // R1: state right after reset release
    p_rst_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ln_q.mask == '1 && ln_q.status == '0));
    // R2: a status bit only rises after an edge was seen on that source
    p_no_spurious_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((ln_q.status & ~$past(ln_q.status) & ~$past(hit_i)) == '0));
    // R9: an edge coinciding with a clear leaves the bit set
    p_edge_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (($past(hit_i & clr) & ~ln_q.status) == '0));
    // R5: mask only moves on a mask write
    p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_mask_i && wr_en_i) |=> $stable(ln_q.mask));
endmodule

// File: rtl/irqb_summary.sv
module irqb_summary #(
    parameter int         SLOT      = 2,
    parameter logic [7:0] SLOT_USED = 8'h3F
) (
    input  logic       own0_i,
    input  logic       own1_i,
    input  logic [7:0] peer0_i,
    input  logic [7:0] peer1_i,
    output logic [7:0] sum0_o,
    output logic [7:0] sum1_o
);
    logic unused_peer;
    assign unused_peer = ^{peer0_i, peer1_i};

    for (genvar n = 0; n < irqb_pkg::SUM_W; n++) begin : g_slot
        if (!SLOT_USED[n]) begin : g_off
            assign sum0_o[n] = 1'b0;
            assign sum1_o[n] = 1'b0;
        end else if (n == SLOT) begin : g_own
            assign sum0_o[n] = own0_i;
            assign sum1_o[n] = own1_i;
        end else begin : g_peer
            assign sum0_o[n] = peer0_i[n];
            assign sum1_o[n] = peer1_i[n];
        end
    end
endmodule

// File: rtl/irqb_bank.sv
module irqb_bank #(
    parameter int         N         = 12,
    parameter int         SLOT      = 2,
    parameter logic [7:0] SLOT_USED = 8'h3F
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src,
    input  logic [7:0]   addr,
    input  logic         wr_en,
    input  logic [7:0]   wr_data,
    input  logic         rd_en,
    output logic [7:0]   rd_data,
    output logic         irq0_n,
    output logic         irq1_n,
    input  logic [7:0]   peer_req0,
    input  logic [7:0]   peer_req1,
    output logic [7:0]   summary0,
    output logic [7:0]   summary1
);
    import irqb_pkg::*;

    localparam int SB = (N + 7) / 8;
    localparam int EB = (2 * N + 7) / 8;

    typedef struct packed {
        logic           cor;
        logic [2*N-1:0] cfg;
    } bank_state_t;

    bank_state_t bk_d, bk_q;

    logic [N-1:0]    hit;
    logic [N-1:0]    st   [LINES];
    logic [N-1:0]    mk   [LINES];
    logic [SB*8-1:0] st_pad [LINES];
    logic [SB*8-1:0] mk_pad [LINES];
    logic [LINES-1:0] req, sel_st, sel_mk;
    logic [EB*8-1:0] cfg_pad, cfg_wr;
    logic            sel_ctrl, sel_edge, sel_any;
    logic [2:0]      lbyte;

    // ---------------- address decode ----------------
    always_comb begin
        lbyte     = addr[2:0];
        sel_ctrl  = (addr == ADDR_CTRL);
        sel_edge  = (addr[7:4] == HI_EDGE) && (int'(addr[3:0]) < EB);
        sel_st[0] = (addr[7:3] == HI_ST0) && (int'(lbyte) < SB);
        sel_mk[0] = (addr[7:3] == HI_MK0) && (int'(lbyte) < SB);
        sel_st[1] = (addr[7:3] == HI_ST1) && (int'(lbyte) < SB);
        sel_mk[1] = (addr[7:3] == HI_MK1) && (int'(lbyte) < SB);
        sel_any   = sel_ctrl | sel_edge | (|sel_st) | (|sel_mk);
    end

    // ---------------- shared configuration ----------------
    always_comb begin
        cfg_pad            = '0;
        cfg_pad[2*N-1:0]   = bk_q.cfg;
        cfg_wr             = cfg_pad;
        cfg_wr[int'(addr[3:0])*8 +: 8] = wr_data;

        bk_d = bk_q;
        if (wr_en && sel_ctrl) bk_d.cor = wr_data[0];
        if (wr_en && sel_edge) bk_d.cfg = cfg_wr[2*N-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    // ---------------- datapath ----------------
    irqb_edge #(.N(N)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .src_i (src),
        .cfg_i (bk_q.cfg),
        .hit_o (hit)
    );

    for (genvar l = 0; l < LINES; l++) begin : g_line
        irqb_line #(.N(N), .SB(SB)) u_line (
            .clk        (clk),
            .rst_n      (rst_n),
            .hit_i      (hit),
            .cor_i      (bk_q.cor),
            .sel_stat_i (sel_st[l]),
            .sel_mask_i (sel_mk[l]),
            .byte_i     (lbyte),
            .rd_en_i    (rd_en),
            .wr_en_i    (wr_en),
            .wr_data_i  (wr_data),
            .status_o   (st[l]),
            .mask_o     (mk[l]),
            .req_o      (req[l])
        );

        always_comb begin
            st_pad[l]          = '0;
            st_pad[l][N-1:0]   = st[l];
            mk_pad[l]          = '0;
            mk_pad[l][N-1:0]   = mk[l];
        end
    end

    assign irq0_n = ~req[0];
    assign irq1_n = ~req[1];

    irqb_summary #(.SLOT(SLOT), .SLOT_USED(SLOT_USED)) u_sum (
        .own0_i  (req[0]),
        .own1_i  (req[1]),
        .peer0_i (peer_req0),
        .peer1_i (peer_req1),
        .sum0_o  (summary0),
        .sum1_o  (summary1)
    );

    // ---------------- read mux ----------------
    always_comb begin
        rd_data = '0;
        if (sel_ctrl)       rd_data = {7'b0, bk_q.cor};
        else if (sel_edge)  rd_data = cfg_pad[int'(addr[3:0])*8 +: 8];
        else if (sel_st[0]) rd_data = st_pad[0][int'(lbyte)*8 +: 8];
        else if (sel_mk[0]) rd_data = mk_pad[0][int'(lbyte)*8 +: 8];
        else if (sel_st[1]) rd_data = st_pad[1][int'(lbyte)*8 +: 8];
        else if (sel_mk[1]) rd_data = mk_pad[1][int'(lbyte)*8 +: 8];
    end

    // R2: edge selection only changes on a write to its region
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel_edge) |=> $stable(bk_q.cfg));
    // R6: acknowledge mode only changes on a control write
    p_cor_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel_ctrl) |=> $stable(bk_q.cor));
    // R10: unmapped reads return zero
    p_unmapped_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !sel_any) |-> (rd_data == 8'h00));
endmodule

// File: tb/test_irqb_bank.sv
`timescale 1ns/1ps
module test_irqb_bank;
    localparam int N = 12;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_SRC = 2'd2, OP_IRQ = 2'd3;
    localparam int NV = 32;
    // {op, req number, addr, data, expected}
    localparam logic [37:0] VEC [NV] = '{
        {OP_RD,  4'd1,  8'h28, 16'h0000, 8'hFF},  // R1 mask0 low byte
        {OP_RD,  4'd10, 8'h29, 16'h0000, 8'h0F},  // R10 bits >= N read 0
        {OP_RD,  4'd1,  8'h38, 16'h0000, 8'hFF},  // R1 mask1
        {OP_RD,  4'd1,  8'h10, 16'h0000, 8'h00},  // R1 edge cfg
        {OP_RD,  4'd1,  8'h00, 16'h0000, 8'h00},  // R1 control
        {OP_IRQ, 4'd1,  8'h00, 16'h0000, 8'h03},  // R1 both lines idle
        {OP_WR,  4'd2,  8'h10, 16'h0002, 8'h00},  // src0 rising
        {OP_WR,  4'd5,  8'h28, 16'h00FE, 8'h00},  // unmask src0 line0
        {OP_SRC, 4'd2,  8'h00, 16'h0001, 8'h00},
        {OP_RD,  4'd3,  8'h20, 16'h0000, 8'h01},  // R3 line0 copy
        {OP_RD,  4'd3,  8'h30, 16'h0000, 8'h01},  // R3 line1 copy
        {OP_IRQ, 4'd4,  8'h00, 16'h0000, 8'h02},  // R4 irq0 low, irq1 masked
        {OP_RD,  4'd7,  8'h20, 16'h0000, 8'h01},  // R7 read does not clear
        {OP_WR,  4'd7,  8'h20, 16'h0001, 8'h00},
        {OP_RD,  4'd7,  8'h20, 16'h0000, 8'h00},  // R7 write-one cleared
        {OP_IRQ, 4'd4,  8'h00, 16'h0000, 8'h03},
        {OP_SRC, 4'd2,  8'h00, 16'h0000, 8'h00},  // falling on rising-only
        {OP_RD,  4'd2,  8'h20, 16'h0000, 8'h00},  // R2
        {OP_WR,  4'd2,  8'h12, 16'h0040, 8'h00},  // src11 falling
        {OP_SRC, 4'd2,  8'h00, 16'h0800, 8'h00},
        {OP_RD,  4'd2,  8'h21, 16'h0000, 8'h00},  // R2 rise ignored
        {OP_SRC, 4'd2,  8'h00, 16'h0000, 8'h00},
        {OP_RD,  4'd2,  8'h21, 16'h0000, 8'h08},  // R2 fall seen, bit 11
        {OP_WR,  4'd6,  8'h00, 16'h0001, 8'h00},  // clear-on-read mode
        {OP_WR,  4'd6,  8'h21, 16'h0008, 8'h00},  // ignored write
        {OP_RD,  4'd6,  8'h21, 16'h0000, 8'h08},  // R6 returned then cleared
        {OP_RD,  4'd6,  8'h21, 16'h0000, 8'h00},  // R6
        {OP_RD,  4'd3,  8'h31, 16'h0000, 8'h08},  // R3 line1 still set
        {OP_RD,  4'd10, 8'h05, 16'h0000, 8'h00},  // R10 unmapped read
        {OP_WR,  4'd10, 8'h05, 16'h00FF, 8'h00},  // unmapped write
        {OP_RD,  4'd10, 8'h00, 16'h0000, 8'h01},  // R10 control unaffected
        {OP_RD,  4'd10, 8'h22, 16'h0000, 8'h00}   // R10 beyond status length
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic [7:0]   addr = '0, wr_data = '0;
    logic         wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]   rd_data, peer_req0 = '0, peer_req1 = '0, summary0, summary1;
    logic         irq0_n, irq1_n;
    int total = 0, bad = 0;

    always #5 clk = ~clk;

    irqb_bank #(.N(N), .SLOT(2), .SLOT_USED(8'h3F)) i_irqb_bank (
        .clk(clk), .rst_n(rst_n), .src(src), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .irq0_n(irq0_n), .irq1_n(irq1_n), .peer_req0(peer_req0),
        .peer_req1(peer_req1), .summary0(summary0), .summary1(summary1)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1;
        chk(rd_data === exp, tag, {8'h00, rd_data}, {8'h00, exp});
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic drive_src(input logic [N-1:0] v);
        @(negedge clk);
        src = v;
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic chk_irq(input logic [1:0] exp, input string tag);
        @(negedge clk);
        chk({irq1_n, irq0_n} === exp, tag, {14'b0, irq1_n, irq0_n}, {14'b0, exp});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            logic [1:0]  op;
            logic [3:0]  rq;
            logic [7:0]  a, e;
            logic [15:0] d;
            {op, rq, a, d, e} = VEC[v];
            case (op)
                OP_WR:  wr(a, d[7:0]);
                OP_RD:  rd(a, e, $sformatf("R%0d row %0d", rq, v));
                OP_SRC: drive_src(d[N-1:0]);
                default: chk_irq(e[1:0], $sformatf("R%0d row %0d", rq, v));
            endcase
        end

        // R8: second edge buffered while set (clear-on-read mode active)
        wr(8'h10, 8'h0E);
        drive_src(12'h002);
        drive_src(12'h000);
        rd(8'h20, 8'h02, "R8 first read");
        rd(8'h20, 8'h02, "R8 second read");
        rd(8'h20, 8'h00, "R8 third read");

        // R9: clear and edge in the same cycle (write-one-to-clear mode)
        wr(8'h00, 8'h00);
        drive_src(12'h001);
        rd(8'h20, 8'h01, "R9 setup");
        drive_src(12'h000);
        @(negedge clk);
        src = 12'h001;
        repeat (2) @(posedge clk);
        @(negedge clk);
        addr = 8'h20; wr_data = 8'h01; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
        rd(8'h20, 8'h01, "R9 edge wins");
        wr(8'h20, 8'h01);
        rd(8'h20, 8'h00, "R9 no stale event");

        // R12: synchronizer latency on src2 rising
        wr(8'h10, 8'h2E);
        @(negedge clk);
        src = 12'h005;
        addr = 8'h20; rd_en = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(rd_data === 8'h00, "R12 after two edges", {8'h00, rd_data}, 16'h0000);
        @(negedge clk);
        chk(rd_data === 8'h04, "R12 after three edges", {8'h00, rd_data}, 16'h0004);
        rd_en = 1'b0;

        // R5 / R4: mask gating of a set status bit
        chk_irq(2'b11, "R5 masked bit held off");
        wr(8'h28, 8'hFB);
        chk_irq(2'b10, "R4 unmasked bit drives irq0");
        wr(8'h28, 8'hFF);
        chk_irq(2'b11, "R5 all-ones mask");

        // R11: summary aggregation
        peer_req0 = 8'hFF; peer_req1 = 8'h80;
        @(negedge clk);
        chk(summary0 === 8'h3B, "R11 summary0 own idle", {8'h00, summary0}, 16'h003B);
        chk(summary1 === 8'h00, "R11 summary1 idle", {8'h00, summary1}, 16'h0000);
        wr(8'h38, 8'hFE);
        @(negedge clk);
        chk(summary1 === 8'h04, "R11 summary1 own slot", {8'h00, summary1}, 16'h0004);
        chk(irq1_n === 1'b0, "R4 irq1 asserted", {15'b0, irq1_n}, 16'h0000);

        // R1: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(8'h30, 8'h00, "R1 status1 after reset");
        rd(8'h38, 8'hFF, "R1 mask1 after reset");
        rd(8'h12, 8'h00, "R1 cfg after reset");
        chk_irq(2'b11, "R1 lines idle after reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule